// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block sits between a synchronous request source and the pins of an asynchronous static RAM. Each request carries an address and one data byte, and it is accepted through a valid/ready handshake. The block turns it into one write cycle on active-low chip-enable, write-enable and output-enable pins. The data byte goes out with a separate drive-enable for the bidirectional data pads. Every timing minimum is a nanosecond parameter. The block converts each one to whole clock cycles by rounding up against a clock-period parameter.

A per-request mode input selects one of two cycle shapes. With the mode input at 0, output-enable stays high and the data driver turns on as soon as write-enable falls. With the mode input at 1, output-enable is held low for the whole cycle. The memory may then still be driving the pads just after write-enable falls, so the data driver waits out that turn-off delay, and write-enable is held low for the longer pulse this case needs. In both modes the write ends when write-enable and chip-enable rise together. Data setup is counted back from that rising edge, and the data driver is released on that same edge.

Top module: `sram_wr_seq`

## Requirements
- R1: `req_ready_o` is high only while idle. A request is taken at a clock edge where `req_valid_i` and `req_ready_o` are both high. Ready then stays low for max(WC−1, W) cycles, where WC = ceil(T_WC_NS/CLK_PERIOD_NS) and W is the pulse length of the mode in use. A request presented while ready is low has no effect.
- R2: Address and data are captured at acceptance. `sram_addr_o` and `sram_data_o` show the captured values, unchanged, for the whole time write-enable is low.
- R3: Write-enable and chip-enable fall together in the cycle after acceptance and rise together.
- R4: In mode 0, `sram_oe_no` stays high. The write-enable low pulse lasts exactly W0 = max(ceil(T_PWE1_NS/T), max(ceil(T_SD_NS/T),1), ceil(T_AW_NS/T), ceil(T_SCE_NS/T)) cycles, where T is CLK_PERIOD_NS.
- R5: In mode 1, `sram_oe_no` is low from the cycle write-enable falls until ready returns. The pulse lasts exactly W1 = max(ceil(T_PWE2_NS/T), HZ+SD, ceil(T_AW_NS/T), ceil(T_SCE_NS/T)) cycles, where HZ = ceil(T_HZWE_NS/T) and SD = max(ceil(T_SD_NS/T),1).
- R6: The data driver (`sram_data_oe_o` high) is on only while write-enable is low. It is on for at least SD cycles before write-enable rises, and it turns off on the edge where write-enable rises.
- R7: In mode 1, the data driver stays off for the first HZ cycles after write-enable falls, then stays on until the write ends.
- R8: In mode 0, the data driver turns on in the same cycle as write-enable falls.
- R9: Two successive falling edges of write-enable are at least WC cycles apart. With valid held high, the second fall comes exactly max(WC, W+1) cycles after the first.
- R10: While `rst_ni` is low, and after it is released, the pins are idle until the first request: chip-enable, write-enable and output-enable high, data driver off, ready high.
- R11: The mode is sampled at acceptance. Changing `oe_low_i` during a cycle does not change that cycle's output-enable level or pulse length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Write request valid |
| req_ready_o | output | 1 | Ready to accept a request |
| req_addr_i | input | ADDR_W | Request address |
| req_data_i | input | 8 | Request data byte |
| oe_low_i | input | 1 | Mode: 1 holds output-enable low during the cycle |
| sram_addr_o | output | ADDR_W | Memory address pins |
| sram_data_o | output | 8 | Data value for the data pads |
| sram_data_oe_o | output | 1 | Drive enable for the data pads |
| sram_ce_no | output | 1 | Chip enable, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_oe_no | output | 1 | Output enable, active low |

## Verification
Two things happen on the same clock edge: write-enable rises to end the write, and the data driver is released. The bench checks this at every cycle of each write, in both modes. It requires the driver to be on in the last low cycle of write-enable and off in the first high one. A second coincidence occurs when the recovery window ends while a new request is already waiting. The bench provokes it by holding valid high across back-to-back writes. It judges the result by the exact gap between the two write-enable falls, and by a held request with junk values leaving the pins unchanged while ready is low.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_REC  = 2'd2
  } wr_state_e;

  function automatic int ns2cyc(input int ns, input int per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_wr_cnt.sv
module sram_wr_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
  import sram_wr_pkg::*;
#(
  parameter int W_HI   = 2,
  parameter int W_LO   = 4,
  parameter int HZ     = 2,
  parameter int REC_HI = 0,
  parameter int REC_LO = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic oe_low_i,
  output logic ready_o,
  output logic accept_o,
  output logic ce_no,
  output logic we_no,
  output logic oe_no,
  output logic de_o
);
  localparam int CMAX  = imax(imax(W_HI, W_LO), imax(REC_HI, REC_LO));
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam logic [CNT_W-1:0] WH_LAST = CNT_W'(W_HI - 1);
  localparam logic [CNT_W-1:0] WL_LAST = CNT_W'(W_LO - 1);
  localparam logic [CNT_W-1:0] RH_LAST = CNT_W'(REC_HI - 1);
  localparam logic [CNT_W-1:0] RL_LAST = CNT_W'(REC_LO - 1);
  localparam logic [CNT_W-1:0] HZ_LAST = CNT_W'(HZ - 1);
  localparam logic HZ_NONE = (HZ == 0);

  wr_state_e        st_q;
  logic             mode_q;
  logic [CNT_W-1:0] cnt, w_last, r_last;
  logic             has_rec, wr_done, rec_done;

  assign w_last   = mode_q ? WL_LAST : WH_LAST;
  assign r_last   = mode_q ? RL_LAST : RH_LAST;
  assign has_rec  = mode_q ? (REC_LO > 0) : (REC_HI > 0);
  assign ready_o  = (st_q == ST_IDLE);
  assign accept_o = req_valid_i & ready_o;
  assign wr_done  = (st_q == ST_WR)  && (cnt == w_last);
  assign rec_done = (st_q == ST_REC) && (cnt == r_last);

  sram_wr_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept_o | wr_done | rec_done),
    .en_i   (st_q != ST_IDLE),
    .cnt_o  (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mode_q <= 1'b0;
      ce_no  <= 1'b1;
      we_no  <= 1'b1;
      oe_no  <= 1'b1;
      de_o   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid_i) begin
          st_q   <= ST_WR;
          mode_q <= oe_low_i;
          ce_no  <= 1'b0;
          we_no  <= 1'b0;
          oe_no  <= ~oe_low_i;
          de_o   <= ~oe_low_i | HZ_NONE;  // mode 1 waits for memory turn-off
        end
        ST_WR: begin
          if (mode_q && cnt == HZ_LAST) de_o <= 1'b1;
          if (wr_done) begin
            ce_no <= 1'b1;
            we_no <= 1'b1;
            de_o  <= 1'b0;               // release pads on the ending edge
            if (has_rec) st_q <= ST_REC;
            else begin
              st_q  <= ST_IDLE;
              oe_no <= 1'b1;
            end
          end
        end
        ST_REC: if (rec_done) begin
          st_q  <= ST_IDLE;
          oe_no <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_wr_bus.sv
module sram_wr_bus #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      data_o <= '0;
    end else if (load_i) begin
      addr_o <= addr_i;
      data_o <= data_i;
    end
  end
endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_WC_NS       = 10,
  parameter int T_PWE1_NS     = 8,
  parameter int T_PWE2_NS     = 10,
  parameter int T_SD_NS       = 6,
  parameter int T_AW_NS       = 8,
  parameter int T_SCE_NS      = 8,
  parameter int T_HZWE_NS     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [7:0]        req_data_i,
  input  logic              oe_low_i,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [7:0]        sram_data_o,
  output logic              sram_data_oe_o,
  output logic              sram_ce_no,
  output logic              sram_we_no,
  output logic              sram_oe_no
);
  localparam int T      = CLK_PERIOD_NS;
  localparam int WC_C   = ns2cyc(T_WC_NS, T);
  localparam int SD_C   = imax(ns2cyc(T_SD_NS, T), 1);
  localparam int HZ_C   = ns2cyc(T_HZWE_NS, T);
  localparam int AS_C   = imax(ns2cyc(T_AW_NS, T), ns2cyc(T_SCE_NS, T));
  localparam int W_HI   = imax(imax(ns2cyc(T_PWE1_NS, T), SD_C), AS_C);
  localparam int W_LO   = imax(imax(ns2cyc(T_PWE2_NS, T), HZ_C + SD_C), AS_C);
  localparam int REC_HI = imax(WC_C - W_HI - 1, 0);
  localparam int REC_LO = imax(WC_C - W_LO - 1, 0);

  logic accept;

  sram_wr_fsm #(
    .W_HI(W_HI), .W_LO(W_LO), .HZ(HZ_C), .REC_HI(REC_HI), .REC_LO(REC_LO)
  ) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .oe_low_i    (oe_low_i),
    .ready_o     (req_ready_o),
    .accept_o    (accept),
    .ce_no       (sram_ce_no),
    .we_no       (sram_we_no),
    .oe_no       (sram_oe_no),
    .de_o        (sram_data_oe_o)
  );

  sram_wr_bus #(.ADDR_W(ADDR_W), .DATA_W(8)) i_bus (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .addr_i (req_addr_i),
    .data_i (req_data_i),
    .addr_o (sram_addr_o),
    .data_o (sram_data_o)
  );
endmodule

// File: rtl/sram_wr_seq_chk.sv
module sram_wr_seq_chk #(
  parameter int ADDR_W        = 19,
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_WC_NS       = 10,
  parameter int T_PWE1_NS     = 8,
  parameter int T_PWE2_NS     = 10,
  parameter int T_SD_NS       = 6,
  parameter int T_HZWE_NS     = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic [7:0]        sram_data_o,
  input logic              sram_data_oe_o,
  input logic              sram_ce_no,
  input logic              sram_we_no,
  input logic              sram_oe_no
);
  logic [7:0] we_lo_cnt, de_cnt, since_fall;
  logic       we_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_lo_cnt  <= '0;
      de_cnt     <= '0;
      since_fall <= 8'hff;
      we_d       <= 1'b1;
    end else begin
      we_d       <= sram_we_no;
      we_lo_cnt  <= sram_we_no ? 8'd0 : we_lo_cnt + 8'd1;
      de_cnt     <= sram_data_oe_o ? de_cnt + 8'd1 : 8'd0;
      if (we_d && !sram_we_no)   since_fall <= 8'd1;
      else if (since_fall != 8'hff) since_fall <= since_fall + 8'd1;
    end
  end

  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> !req_ready_o); // R1
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_we_no && $past(!sram_we_no)) |-> ($stable(sram_addr_o) && $stable(sram_data_o))); // R2
  AST_CE_WITH_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_we_no == sram_ce_no); // R3
  AST_PWE1_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sram_we_no) && $past(sram_oe_no)) |-> (int'(we_lo_cnt) * CLK_PERIOD_NS >= T_PWE1_NS)); // R4
  AST_PWE2_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sram_we_no) && !$past(sram_oe_no)) |-> (int'(we_lo_cnt) * CLK_PERIOD_NS >= T_PWE2_NS)); // R5
  AST_DATA_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (int'(de_cnt) * CLK_PERIOD_NS >= T_SD_NS)); // R6
  AST_DRIVE_IN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_data_oe_o |-> !sram_we_no); // R6
  AST_HZ_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sram_data_oe_o) && !sram_oe_no) |-> (int'(we_lo_cnt) * CLK_PERIOD_NS >= T_HZWE_NS)); // R7
  AST_CYCLE_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_we_no) |-> (int'(since_fall) * CLK_PERIOD_NS >= T_WC_NS)); // R9
endmodule

bind sram_wr_seq sram_wr_seq_chk #(
  .ADDR_W(ADDR_W), .CLK_PERIOD_NS(CLK_PERIOD_NS), .T_WC_NS(T_WC_NS),
  .T_PWE1_NS(T_PWE1_NS), .T_PWE2_NS(T_PWE2_NS), .T_SD_NS(T_SD_NS), .T_HZWE_NS(T_HZWE_NS)
) i_sram_wr_seq_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_ready_o    (req_ready_o),
  .sram_addr_o    (sram_addr_o),
  .sram_data_o    (sram_data_o),
  .sram_data_oe_o (sram_data_oe_o),
  .sram_ce_no     (sram_ce_no),
  .sram_we_no     (sram_we_no),
  .sram_oe_no     (sram_oe_no)
);

// File: tb/test_sram_wr_seq.sv
module test_sram_wr_seq;
  localparam int AW  = 19;
  localparam int T   = 4;
  localparam int WCN = 28;  // long cycle time so the recovery window is exercised

  function automatic int cyc(input int ns); return (ns + T - 1) / T; endfunction
  function automatic int mx(input int a, input int b); return (a > b) ? a : b; endfunction

  localparam int SD  = mx(cyc(6), 1);
  localparam int HZ  = cyc(5);
  localparam int WC  = cyc(WCN);
  localparam int ASC = mx(cyc(8), cyc(8));
  localparam int W0  = mx(mx(cyc(8), SD), ASC);
  localparam int W1  = mx(mx(cyc(10), HZ + SD), ASC);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    data = '0;
  logic          mode = 1'b0;
  logic          ready, de, ce_n, we_n, oe_n;
  logic [AW-1:0] s_addr;
  logic [7:0]    s_data;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(T / 2) clk = ~clk;

  sram_wr_seq #(.CLK_PERIOD_NS(T), .T_WC_NS(WCN)) i_sram_wr_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_addr_i(addr), .req_data_i(data), .oe_low_i(mode),
    .sram_addr_o(s_addr), .sram_data_o(s_data), .sram_data_oe_o(de),
    .sram_ce_no(ce_n), .sram_we_no(we_n), .sram_oe_no(oe_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_idle(input string req);
    chk(ready == 1'b1, req, ready, 1);
    chk(ce_n == 1'b1 && we_n == 1'b1, req, {ce_n, we_n}, 3);
    chk(oe_n == 1'b1, req, oe_n, 1);
    chk(de == 1'b0, req, de, 0);
  endtask

  // one write; hold: keep valid high with junk while busy; flip: toggle mode mid-cycle
  task automatic run_write(input bit m, input logic [AW-1:0] a, input logic [7:0] d,
                           input bit hold, input bit flip);
    int w, busy;
    w    = m ? W1 : W0;
    busy = mx(WC - 1, w);
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready before request", ready, 1);
    valid = 1'b1; addr = a; data = d; mode = m;
    @(negedge clk);
    valid = hold;
    if (hold) begin addr = ~a; data = ~d; end
    if (flip) mode = ~m;
    for (int k = 0; k <= busy; k++) begin
      bit exp_de;
      exp_de = (k < w) && (m ? (k >= HZ) : 1'b1);
      chk(we_n == (k >= w), m ? "R5 write-enable pulse" : "R4 write-enable pulse", we_n, k >= w);
      chk(ce_n == we_n, "R3 chip-enable tracks write-enable", ce_n, we_n);
      chk(de == exp_de, m ? "R7 drive delay" : "R8 drive at fall", de, exp_de);
      chk(oe_n == !(m && k < busy), flip ? "R11 mode held" : "R5 output-enable level",
          oe_n, !(m && k < busy));
      chk(ready == (k >= busy), "R1 ready window", ready, k >= busy);
      if (k < w) begin
        chk(s_addr == a, "R2 address", int'(s_addr), int'(a));
        chk(s_data == d, "R2 data", s_data, d);
      end
      if (k == w - 1) chk(de == 1'b1, "R6 drive on before end", de, 1);
      if (k == w)     chk(de == 1'b0, "R6 drive off at end", de, 0);
      if (hold && k == busy - 1) valid = 1'b0;
      @(negedge clk);
    end
    chk(we_n == 1'b1, "R1 held request ignored", we_n, 1);
    mode = 1'b0;
  endtask

  task automatic run_b2b(input bit m);
    int gap, w;
    w = m ? W1 : W0;
    @(negedge clk);
    valid = 1'b1; mode = m; addr = 19'h1234; data = 8'h11;
    @(negedge clk);
    addr = 19'h4321; data = 8'h22;
    gap = 0;
    while (we_n == 1'b0) begin gap++; @(negedge clk); end
    while (we_n == 1'b1 && gap < 64) begin gap++; @(negedge clk); end
    valid = 1'b0;
    chk(gap == mx(WC, w + 1), "R9 fall-to-fall spacing", gap, mx(WC, w + 1));
    chk(gap >= WC, "R9 minimum cycle time", gap, WC);
    chk(s_addr == 19'h4321, "R2 second address", int'(s_addr), 'h4321);
    while (ready == 1'b0) @(negedge clk);
    mode = 1'b0;
  endtask

  initial begin
    #(T * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R10 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R10 after reset");
    run_write(1'b0, 19'h0_0a5a, 8'h3c, 1'b0, 1'b0);
    run_write(1'b1, 19'h7_ffff, 8'hc3, 1'b0, 1'b0);
    run_write(1'b0, 19'h0_0000, 8'hff, 1'b1, 1'b0);
    run_write(1'b1, 19'h5_5555, 8'h00, 1'b1, 1'b1);
    run_write(1'b0, 19'h2_aaaa, 8'h81, 1'b0, 1'b1);
    run_b2b(1'b0);
    run_b2b(1'b1);
    repeat (2) @(negedge clk);
    check_idle("R10 idle at end");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule